// File: doc/BRIEF.md
# Partition Spanning Tree Builder Node

This block sits at one node of a network of processing nodes. Its job is to work out, without any global clock or barrier, which of its links lead to children and which one leads to its parent in a spanning tree. That tree covers only the node's own partition. Each node carries a partition number, and it knows the partition number of the node on the far side of each of its `DEG` links. Links that lead into another partition are drained and never explored. The tree is grown as a breadth-first flood of request messages. The first request a node accepts wins, so any race between competing requests still ends in a valid spanning tree.

One node of the partition is told to act as root. It behaves as if it had received a request from itself: it joins with no parent and sends a request on every link inside its partition. A node that is not yet joined accepts the first request it sees. It takes that link as its parent, answers with a positive acknowledge, and floods requests to all of its in-partition links. Any later request is answered with a negative acknowledge. Acknowledges coming back from the neighbours record which links are children. Each in-partition link delivers exactly one request and one acknowledge, so the node is finished after twice its in-partition degree of messages. A dissolve command tears the tree down and makes the node ready for a new build.

Top module: `span_tree_node`

## Requirements
- R1: After reset, `child_n` and `parent_n` read all ones (no child, no parent), `done` is low and no link transmits.
- R2: A `start_root` pulse on an idle node sends a request on every in-partition link, visible on `tx_valid` one clock after the pulse, and leaves `parent_n` at all ones.
- R3: On an idle node, the first accepted request on link i clears bit i of `parent_n`. It also queues a positive acknowledge on link i and a request on every in-partition link. On link i the acknowledge is sent before the request. These transmissions start one clock after acceptance.
- R4: A request accepted by a node that has already joined is answered with a negative acknowledge on the same link, and the parent mask does not change.
- R5: A positive acknowledge on link i clears bit i of `child_n` (link i is a child). A negative acknowledge sets bit i (not a child).
- R6: `done` rises once the node has joined and has counted twice as many messages as it has in-partition links. A root with no in-partition links finishes with no messages. `done` stays high until dissolve or reset.
- R7: A link whose neighbour partition number differs from `my_pid` always has `rx_ready` high. Its messages are dropped and not counted, and no message is ever transmitted on it.
- R8: When several in-partition links offer messages in the same cycle, only the lowest-numbered one is accepted, one per clock, with `rx_ready` high for that link alone.
- R9: A `dissolve` pulse returns the node to idle: both masks read all ones, `done` falls and queued transmissions are dropped, all by the next clock.
- R10: Message codes on a link are 2 bits: 00 idle, 01 request, 10 positive acknowledge, 11 negative acknowledge. A valid message with code 00 is accepted and has no effect. The node never transmits code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_pid | input | PID_W | Partition number of this node |
| nbr_pid | input | DEG*PID_W | Partition number of the neighbour on each link, link i at bits [i*PID_W +: PID_W] |
| start_root | input | 1 | Pulse: this node becomes the root and starts the build |
| dissolve | input | 1 | Pulse: discard the tree and return to idle |
| rx_valid | input | DEG | Incoming message valid, one bit per link |
| rx_code | input | 2*DEG | Incoming message code, link i at bits [2i+1:2i] |
| rx_ready | output | DEG | Incoming message accepted, one bit per link |
| tx_valid | output | DEG | Outgoing message valid, one bit per link |
| tx_code | output | 2*DEG | Outgoing message code, link i at bits [2i+1:2i] |
| tx_ready | input | DEG | Neighbour takes the outgoing message |
| child_n | output | DEG | Child mask, bit low means the link leads to a child |
| parent_n | output | DEG | Parent mask, bit low means the link leads to the parent |
| done | output | 1 | Build finished at this node |

## Verification
The build is driven in three shapes. The first is a non-root node that has one foreign link, receives its joining request on a middle link and then gets two late requests at the same time. This separates the first-request-wins path from the negative-acknowledge path and tests the port priority. The second is a root whose links all lie inside the partition, which checks the self-started flood and completion at eight messages. The third is a root whose links are all foreign, which checks completion with zero degree. A scoreboard holds every message the node must send, in order, so a missing, extra, misordered or miscoded acknowledge shows up as a mismatch. Spurious idle-code messages and foreign-link traffic are injected between real messages, and the masks and `done` are checked afterwards to show that neither had any effect.

// File: rtl/span_tree_pkg.sv
package span_tree_pkg;

    typedef enum logic [1:0] {
        MSG_IDLE = 2'b00,
        MSG_REQ  = 2'b01,
        MSG_POS  = 2'b10,
        MSG_NEG  = 2'b11
    } msg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_GROW = 2'b01,
        ST_DONE = 2'b10
    } node_st_e;

    typedef struct packed {
        logic req;
        logic ack;
        logic pos;
    } tx_slot_t;

    function automatic logic msg_counts(msg_e m);
        return m != MSG_IDLE;
    endfunction

    function automatic msg_e ack_code(logic positive);
        return positive ? MSG_POS : MSG_NEG;
    endfunction

endpackage

// File: rtl/span_part_match.sv
module span_part_match #(
    parameter int DEG   = 4,
    parameter int PID_W = 8
) (
    input  logic [PID_W-1:0]     my_pid,
    input  logic [DEG*PID_W-1:0] nbr_pid,
    output logic [DEG-1:0]       same_part
);

    for (genvar i = 0; i < DEG; i++) begin : g_cmp
        assign same_part[i] = (nbr_pid[i*PID_W +: PID_W] == my_pid);
    end

endmodule

// File: rtl/span_rx_arbiter.sv
module span_rx_arbiter #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/span_tx_port.sv
module span_tx_port
    import span_tree_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic set_req,
    input  logic set_ack,
    input  logic ack_pos,
    input  logic tx_ready,
    output logic tx_valid,
    output msg_e tx_code
);

    tx_slot_t slot;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot <= '0;
        end else begin
            if (tx_valid && tx_ready) begin
                if (slot.ack) begin
                    slot.ack <= 1'b0;
                end else begin
                    slot.req <= 1'b0;
                end
            end
            if (set_req) begin
                slot.req <= 1'b1;
            end
            if (set_ack) begin
                slot.ack <= 1'b1;
                slot.pos <= ack_pos;
            end
        end
    end

    assign tx_valid = slot.ack | slot.req;
    assign tx_code  = slot.ack ? ack_code(slot.pos) : MSG_REQ;

    // R4: a link carries one request in, so only one acknowledge may wait
    assert_ack_slot_R4: assert property (@(posedge clk) disable iff (rst)
        set_ack |-> !slot.ack);

    // R3: a node floods only once per build
    assert_req_slot_R3: assert property (@(posedge clk) disable iff (rst)
        set_req |-> !slot.req);

    // R10: the idle code is never put on the wire
    assert_tx_code_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_code != MSG_IDLE));

endmodule

// File: rtl/span_tree_node.sv
module span_tree_node
    import span_tree_pkg::*;
#(
    parameter int DEG   = 4,
    parameter int PID_W = 8,
    localparam int IDX_W = (DEG > 1) ? $clog2(DEG) : 1,
    localparam int CNT_W = $clog2(2 * DEG + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PID_W-1:0]     my_pid,
    input  logic [DEG*PID_W-1:0] nbr_pid,
    input  logic                 start_root,
    input  logic                 dissolve,
    input  logic [DEG-1:0]       rx_valid,
    input  logic [2*DEG-1:0]     rx_code,
    output logic [DEG-1:0]       rx_ready,
    output logic [DEG-1:0]       tx_valid,
    output logic [2*DEG-1:0]     tx_code,
    input  logic [DEG-1:0]       tx_ready,
    output logic [DEG-1:0]       child_n,
    output logic [DEG-1:0]       parent_n,
    output logic                 done
);

    node_st_e         state;
    logic [CNT_W-1:0] msg_cnt;
    logic [CNT_W-1:0] target;
    logic [DEG-1:0]   same_part;
    logic [DEG-1:0]   arb_req;
    logic [DEG-1:0]   gnt;
    logic [IDX_W-1:0] sel_idx;
    logic             take;
    logic             hold;
    msg_e             sel_code;
    logic             root_start;
    logic             join_evt;
    logic             is_idle;
    logic [DEG-1:0]   set_req;
    logic [DEG-1:0]   set_ack;

    span_part_match #(.DEG(DEG), .PID_W(PID_W)) i_match (
        .my_pid   (my_pid),
        .nbr_pid  (nbr_pid),
        .same_part(same_part)
    );

    assign is_idle    = (state == ST_IDLE);
    assign root_start = start_root && is_idle && !dissolve;
    assign hold       = dissolve || (start_root && is_idle);
    assign arb_req    = rx_valid & same_part & {DEG{~hold}};

    span_rx_arbiter #(.N(DEG)) i_arb (
        .req(arb_req),
        .gnt(gnt),
        .idx(sel_idx),
        .any(take)
    );

    assign rx_ready = gnt | ~same_part;
    assign sel_code = msg_e'(rx_code[2*sel_idx +: 2]);

    always_comb begin
        target = '0;
        for (int i = 0; i < DEG; i++) begin
            if (same_part[i]) begin
                target = target + CNT_W'(2);
            end
        end
    end

    assign join_evt = root_start || (take && sel_code == MSG_REQ && is_idle);

    always_comb begin
        for (int i = 0; i < DEG; i++) begin
            set_req[i] = join_evt && same_part[i];
            set_ack[i] = take && gnt[i] && (sel_code == MSG_REQ);
        end
    end

    for (genvar i = 0; i < DEG; i++) begin : g_tx
        msg_e code_i;
        span_tx_port i_port (
            .clk     (clk),
            .rst     (rst),
            .clear   (dissolve),
            .set_req (set_req[i]),
            .set_ack (set_ack[i]),
            .ack_pos (is_idle),
            .tx_ready(tx_ready[i]),
            .tx_valid(tx_valid[i]),
            .tx_code (code_i)
        );
        assign tx_code[2*i +: 2] = code_i;
    end

    always_ff @(posedge clk) begin
        if (rst || dissolve) begin
            state    <= ST_IDLE;
            msg_cnt  <= '0;
            child_n  <= '1;
            parent_n <= '1;
        end else begin
            if (root_start) begin
                state <= ST_GROW;
            end else if (take) begin
                if (msg_counts(sel_code)) begin
                    msg_cnt <= msg_cnt + CNT_W'(1);
                end
                case (sel_code)
                    MSG_REQ: begin
                        if (is_idle) begin
                            parent_n[sel_idx] <= 1'b0;
                            state             <= ST_GROW;
                        end
                    end
                    MSG_POS: child_n[sel_idx] <= 1'b0;
                    MSG_NEG: child_n[sel_idx] <= 1'b1;
                    default: ;
                endcase
            end
            if (state == ST_GROW && msg_cnt == target) begin
                state <= ST_DONE;
            end
        end
    end

    assign done = (state == ST_DONE);

    // R1: cleared state right after reset
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (child_n == '1 && parent_n == '1 && !done && tx_valid == '0));

    // R2: the root keeps no parent
    assert_root_parent_R2: assert property (@(posedge clk) disable iff (rst)
        root_start |=> (parent_n == '1));

    // R3: at most one parent link
    assert_parent_single_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~parent_n));

    // R6: completion holds until dissolved
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !dissolve) |=> done);

    // R7: foreign links never transmit
    assert_no_foreign_tx_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid & ~same_part) == '0);

    // R8: one in-partition message taken per clock
    assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_ready & same_part));

    // R9: dissolve clears the tree by the next clock
    assert_dissolve_clear_R9: assert property (@(posedge clk) disable iff (rst)
        dissolve |=> (child_n == '1 && parent_n == '1 && !done && tx_valid == '0));

endmodule

// File: tb/test_span_tree_node.sv
module test_span_tree_node;

    localparam int DEG   = 4;
    localparam int PID_W = 8;
    localparam logic [1:0] C_IDLE = 2'b00;
    localparam logic [1:0] C_REQ  = 2'b01;
    localparam logic [1:0] C_POS  = 2'b10;
    localparam logic [1:0] C_NEG  = 2'b11;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [PID_W-1:0]     my_pid = 8'd5;
    logic [DEG*PID_W-1:0] nbr_pid = '0;
    logic                 start_root = 1'b0;
    logic                 dissolve = 1'b0;
    logic [DEG-1:0]       rx_valid = '0;
    logic [2*DEG-1:0]     rx_code = '0;
    logic [DEG-1:0]       rx_ready;
    logic [DEG-1:0]       tx_valid;
    logic [2*DEG-1:0]     tx_code;
    logic [DEG-1:0]       tx_ready = '1;
    logic [DEG-1:0]       child_n;
    logic [DEG-1:0]       parent_n;
    logic                 done;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_link[$];
    logic [1:0] exp_code[$];

    always #4 clk = ~clk;

    span_tree_node #(.DEG(DEG), .PID_W(PID_W)) i_span_tree_node (
        .clk(clk), .rst(rst), .my_pid(my_pid), .nbr_pid(nbr_pid),
        .start_root(start_root), .dissolve(dissolve),
        .rx_valid(rx_valid), .rx_code(rx_code), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_code(tx_code), .tx_ready(tx_ready),
        .child_n(child_n), .parent_n(parent_n), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_tx(input int link, input logic [1:0] code);
        exp_link.push_back(link);
        exp_code.push_back(code);
    endtask

    task automatic send(input int link, input logic [1:0] code);
        @(negedge clk);
        rx_valid[link] = 1'b1;
        rx_code[2*link +: 2] = code;
        #1;
        while (!rx_ready[link]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rx_valid[link] = 1'b0;
        rx_code[2*link +: 2] = C_IDLE;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor: every transmitted message must match the next expected one
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < DEG; i++) begin
                if (tx_valid[i] && tx_ready[i]) begin
                    if (exp_link.size() == 0) begin
                        check(1'b0, "R3/R4 unexpected tx", 32'(i), 32'hFFFF);
                    end else begin
                        int el;
                        logic [1:0] ec;
                        el = exp_link.pop_front();
                        ec = exp_code.pop_front();
                        check(el == i && ec == tx_code[2*i +: 2], "R3/R4/R10 tx order",
                              {16'(i), 14'd0, tx_code[2*i +: 2]}, {16'(el), 14'd0, ec});
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        nbr_pid = {8'd9, 8'd5, 8'd5, 8'd5};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(child_n == 4'hF && parent_n == 4'hF, "R1 masks", {child_n, parent_n}, 8'hFF);
        check(!done && tx_valid == 0, "R1 idle", {done, tx_valid}, 0);

        // R7: foreign link traffic is drained and ignored
        send(3, C_REQ);
        idle(3);
        check(tx_valid == 0 && parent_n == 4'hF, "R7 foreign ignored", {tx_valid, parent_n}, 8'h0F);

        // R3: join through link 1
        expect_tx(0, C_REQ); expect_tx(1, C_POS); expect_tx(2, C_REQ); expect_tx(1, C_REQ);
        send(1, C_REQ);
        check(tx_valid == 4'b0111, "R3 flood timing", tx_valid, 4'b0111);
        check(parent_n == 4'b1101, "R3 parent", parent_n, 4'b1101);
        idle(4);

        // R8 + R4: simultaneous late requests on links 0 and 2
        expect_tx(0, C_NEG); expect_tx(2, C_NEG);
        @(negedge clk);
        rx_valid[0] = 1'b1; rx_code[1:0] = C_REQ;
        rx_valid[2] = 1'b1; rx_code[5:4] = C_REQ;
        #1;
        check((rx_ready & 4'b0111) == 4'b0001, "R8 priority", rx_ready, 4'b0001);
        @(negedge clk);
        rx_valid[0] = 1'b0; rx_code[1:0] = C_IDLE;
        #1;
        check((rx_ready & 4'b0111) == 4'b0100, "R8 next port", rx_ready, 4'b0100);
        @(negedge clk);
        rx_valid[2] = 1'b0; rx_code[5:4] = C_IDLE;
        idle(3);
        check(parent_n == 4'b1101, "R4 parent unchanged", parent_n, 4'b1101);

        // R5: acknowledges
        send(0, C_POS);
        send(1, C_NEG);
        idle(2);
        check(child_n == 4'b1110, "R5 child mask", child_n, 4'b1110);
        check(!done, "R6 not yet done at 5 of 6", done, 0);
        send(0, C_IDLE);
        idle(3);
        check(!done && child_n == 4'b1110, "R10 idle code no effect", {done, child_n}, 5'b01110);
        send(2, C_NEG);
        idle(3);
        check(done && child_n == 4'b1110, "R6 done at 6", {done, child_n}, 5'b11110);

        // R9: dissolve
        @(negedge clk); dissolve = 1'b1;
        @(negedge clk); dissolve = 1'b0;
        check(child_n == 4'hF && parent_n == 4'hF && !done, "R9 dissolve", {done, child_n, parent_n}, 9'h0FF);

        // R2: root with four in-partition links
        nbr_pid = {8'd5, 8'd5, 8'd5, 8'd5};
        for (int i = 0; i < DEG; i++) expect_tx(i, C_REQ);
        @(negedge clk); start_root = 1'b1;
        @(negedge clk); start_root = 1'b0;
        check(tx_valid == 4'hF, "R2 root flood", tx_valid, 4'hF);
        check(parent_n == 4'hF, "R2 root no parent", parent_n, 4'hF);
        idle(2);
        for (int i = 0; i < DEG; i++) begin
            expect_tx(i, C_NEG);
            send(i, C_REQ);
        end
        send(0, C_NEG);
        send(1, C_POS);
        send(2, C_NEG);
        idle(3);
        check(!done, "R6 root not done at 7", done, 0);
        send(3, C_POS);
        idle(3);
        check(done && child_n == 4'b0101 && parent_n == 4'hF, "R6/R5 root done",
              {done, child_n, parent_n}, 9'h15F);

        @(negedge clk); dissolve = 1'b1;
        @(negedge clk); dissolve = 1'b0;

        // R6 + R7: root whose links are all foreign finishes at once
        nbr_pid = {8'd9, 8'd9, 8'd9, 8'd9};
        @(negedge clk); start_root = 1'b1;
        @(negedge clk); start_root = 1'b0;
        idle(3);
        check(done && tx_valid == 0, "R6 zero degree root", {done, tx_valid}, 5'h10);

        idle(2);
        check(exp_link.size() == 0, "R3/R4 all expected tx seen", exp_link.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule